// File: doc/BRIEF.md
# Local Bus Chip-Select Decoder with 16-bit SRAM Width Adapter

This block sits behind a PCI target bridge on a board's local bus. Every access it receives is aimed at one of two windows. The first is a small peripheral window holding four CAN controllers and a read-only byte of digital inputs. The second is a 1 MB battery-backed static RAM.

In the peripheral window, each controller owns a 1 kB slot but answers only in the first 256 bytes of that slot. Every other offset is reserved and selects nothing. The RAM is built from two 512 kB devices that share a 16-bit data path. A host access of 8, 16 or 32 bits is therefore turned into one or two 16-bit device cycles, with the correct device enable and byte lanes for each cycle.

The host holds a request until the block answers with a one-cycle acknowledge. The block captures the request when it accepts it, runs the device cycles, and then returns the read data together with the acknowledge.

Top module: `lbus_csel_bridge`

## Requirements
- R1: While reset is held and after its release, `ack` is low, `rd_data` is zero, all chip selects (`can_cs_n`, `sram_ce_n`) are high and `din_rd` is low.
- R2: A peripheral access with offset bits 19:12 zero and offset bits 9:8 zero selects controller number bits 11:10 by driving that `can_cs_n` bit low for exactly one cycle. In that cycle `can_addr` carries offset bits 7:0, and `can_rd_n` or `can_wr_n` is low according to the direction. At most one device select of any kind is active in a cycle.
- R3: A peripheral access to any other offset is reserved, except offset FFFh. A reserved access drives no select and no strobe, and a reserved read returns FFFFFFFFh.
- R4: A read at offset FFFh asserts `din_rd` for one cycle and returns the `din_value` byte. A write there asserts neither `din_rd` nor any controller select.
- R5: On a controller write, `can_wdata` is the byte of `req_wdata` in lane `req_addr[1:0]`, where lane n is bits 8n+7:8n. On a peripheral read, the returned byte is copied into all four lanes of `rd_data`.
- R6: A RAM access with address bit 19 set enables only `sram_ce_n[1]`, and with bit 19 clear enables only `sram_ce_n[0]`. `sram_addr` is `{req_addr[18:2], h}`, where h is the 16-bit half being transferred.
- R7: Half 0 of a RAM access uses `req_be[1:0]` and half 1 uses `req_be[3:2]`. Within a half, `sram_lane_n[0]` (low byte) and `sram_lane_n[1]` (high byte) are the active-low copies of those enables. A half with no enable runs no device cycle. Read bytes whose enable is clear return zero.
- R8: When both halves are enabled, half 0 runs in the cycle before half 1. A written 32-bit value reads back whole.
- R9: `ack` is high for exactly one cycle per accepted request. Counting from the accepting clock edge, it rises one edge later for a peripheral access, and k edges later for a RAM access with k enabled halves (k = 0 gives `ack` straight after the accepting edge).
- R10: Request inputs are sampled only when the block is idle. A request presented in the same cycle as the previous `ack` is accepted one edge later and completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until `ack` |
| req_ram | input | 1 | 1 selects the RAM window, 0 selects the peripheral window |
| req_addr | input | 20 | Byte offset inside the selected window |
| req_be | input | 4 | Byte enables of the 32-bit RAM word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid while `ack` is high |
| can_cs_n | output | 4 | Active-low controller selects |
| can_rd_n | output | 1 | Active-low controller read strobe |
| can_wr_n | output | 1 | Active-low controller write strobe |
| can_addr | output | 8 | Controller register offset |
| can_wdata | output | 8 | Controller write byte |
| can_rdata | input | 8 | Controller read byte |
| din_rd | output | 1 | Digital input register read strobe |
| din_value | input | 8 | Digital input byte |
| sram_ce_n | output | 2 | Active-low enables of the two RAM devices |
| sram_addr | output | 18 | 16-bit word address inside a device |
| sram_lane_n | output | 2 | Active-low byte lanes (bit 1 = upper byte) |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_wdata | output | 16 | RAM write data |
| sram_rdata | input | 16 | RAM read data |

## Verification
Two things can fall in the same cycle: the acknowledge of one access and the arrival of the next request. The bench provokes this by loading new address, window and direction values in the very cycle it sees `ack`, while keeping `req_valid` high. It then judges three things. The scoreboard must receive exactly one result per `ack`. The first access's data must be unaffected by the new inputs. The second access must be accepted one edge later, with its own select and its own data. A second overlap is also checked: a RAM read whose two halves land in consecutive cycles is verified lane by lane against a bench-side memory image.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

  // Sequencer phases of one local bus access
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PER  = 2'd1,
    SQ_RAM  = 2'd2,
    SQ_DONE = 2'd3
  } sq_state_t;

  // Index of the lowest set bit of an 8-bit mask (0 when empty)
  function automatic int unsigned first_set(input logic [7:0] m);
    int unsigned r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // Expand per-byte enables into a bit mask, one byte per enable
  function automatic logic [15:0] byte_keep(input logic [1:0] en);
    return {{8{en[1]}}, {8{en[0]}}};
  endfunction

endpackage

// File: rtl/lbx_win_decode.sv
module lbx_win_decode #(
  parameter int ADDR_W    = 20,
  parameter int N_CAN     = 4,
  parameter int SLOT_BITS = 10,
  parameter int REG_BITS  = 8,
  localparam int IDX_W    = $clog2(N_CAN),
  localparam int WIN_BITS = SLOT_BITS + IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_can,
  output logic              hit_din,
  output logic              reserved,
  output logic [IDX_W-1:0]  can_idx
);

  logic in_window;
  logic in_regs;
  logic at_last;

  always_comb begin
    in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
    in_regs   = (addr[SLOT_BITS-1:REG_BITS] == '0);
    at_last   = &addr[WIN_BITS-1:0];
    hit_can   = in_window && in_regs;
    hit_din   = in_window && at_last && !in_regs;
    reserved  = !hit_can && !hit_din;
    can_idx   = addr[WIN_BITS-1:SLOT_BITS];
  end

endmodule

// File: rtl/lbx_sram_port.sv
module lbx_sram_port #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int SRAM_W    = 16,
  parameter int DEV_CNT   = 2,
  localparam int LANES     = SRAM_W / 8,
  localparam int HALVES    = DATA_W / SRAM_W,
  localparam int HALF_W    = $clog2(HALVES),
  localparam int LANE_BITS = $clog2(LANES),
  localparam int DEV_BITS  = $clog2(DEV_CNT),
  localparam int SA_W      = ADDR_W - DEV_BITS - LANE_BITS,
  localparam int HI_LSB    = LANE_BITS + HALF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    write,
  input  logic [ADDR_W-1:HI_LSB]  addr_hi,
  input  logic [DATA_W/8-1:0]     be,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [HALF_W-1:0]       half,
  output logic [DEV_CNT-1:0]      ce_n,
  output logic [SA_W-1:0]         word_addr,
  output logic [LANES-1:0]        lane_n,
  output logic                    we_n,
  output logic                    oe_n,
  output logic [SRAM_W-1:0]       wr_half,
  output logic [SRAM_W-1:0]       keep_mask
);

  logic [DEV_BITS-1:0] dev_sel;
  logic [LANES-1:0]    half_be;

  always_comb begin
    dev_sel   = addr_hi[ADDR_W-1 -: DEV_BITS];
    half_be   = be[int'(half)*LANES +: LANES];
    word_addr = {addr_hi[ADDR_W-DEV_BITS-1:HI_LSB], half};
    wr_half   = wdata[int'(half)*SRAM_W +: SRAM_W];
    we_n      = !(active && write);
    oe_n      = !(active && !write);
  end

  for (genvar d = 0; d < DEV_CNT; d++) begin : g_dev
    assign ce_n[d] = !(active && (dev_sel == DEV_BITS'(d)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_n[l]              = !(active && half_be[l]);
    assign keep_mask[l*8 +: 8]    = {8{half_be[l]}};
  end

  AST_SRAM_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ce_n)); // R6
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !oe_n) |-> !(&ce_n)); // R6
  AST_LANE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !(&lane_n) |-> !(&ce_n)); // R7

endmodule

// File: rtl/lbus_csel_bridge.sv
module lbus_csel_bridge
  import lbx_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int SRAM_W    = 16,
  parameter int N_CAN     = 4,
  parameter int SLOT_BITS = 10,
  parameter int REG_BITS  = 8,
  parameter int DEV_CNT   = 2,
  localparam int BYTES     = DATA_W / 8,
  localparam int LANES     = SRAM_W / 8,
  localparam int HALVES    = DATA_W / SRAM_W,
  localparam int HALF_W    = $clog2(HALVES),
  localparam int LANE_BITS = $clog2(LANES),
  localparam int DEV_BITS  = $clog2(DEV_CNT),
  localparam int SA_W      = ADDR_W - DEV_BITS - LANE_BITS,
  localparam int IDX_W     = $clog2(N_CAN),
  localparam int BSEL_W    = $clog2(BYTES),
  localparam int HI_LSB    = LANE_BITS + HALF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_ram,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BYTES-1:0]     req_be,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 ack,
  output logic [DATA_W-1:0]    rd_data,
  output logic [N_CAN-1:0]     can_cs_n,
  output logic                 can_rd_n,
  output logic                 can_wr_n,
  output logic [REG_BITS-1:0]  can_addr,
  output logic [7:0]           can_wdata,
  input  logic [7:0]           can_rdata,
  output logic                 din_rd,
  input  logic [7:0]           din_value,
  output logic [DEV_CNT-1:0]   sram_ce_n,
  output logic [SA_W-1:0]      sram_addr,
  output logic [LANES-1:0]     sram_lane_n,
  output logic                 sram_we_n,
  output logic                 sram_oe_n,
  output logic [SRAM_W-1:0]    sram_wdata,
  input  logic [SRAM_W-1:0]    sram_rdata
);

  // Latched request
  sq_state_t            state;
  logic                 r_write;
  logic [ADDR_W-1:0]    r_addr;
  logic [BYTES-1:0]     r_be;
  logic [DATA_W-1:0]    r_wdata;
  logic [HALVES-1:0]    pend;
  logic [DATA_W-1:0]    rdata_q;

  // Named internal events
  logic                 acc_start;
  logic                 per_cycle;
  logic                 ram_cycle;
  logic                 acc_done;
  logic [HALVES-1:0]    start_mask;
  logic [HALVES-1:0]    pend_next;
  logic [HALF_W-1:0]    cur_half;
  logic [DATA_W-1:0]    per_rd;
  logic [SRAM_W-1:0]    keep_mask;
  int                   bsel;

  // Decoder outputs
  logic                 dec_can;
  logic                 dec_din;
  logic                 dec_reserved;
  logic [IDX_W-1:0]     dec_idx;

  lbx_win_decode #(
    .ADDR_W    (ADDR_W),
    .N_CAN     (N_CAN),
    .SLOT_BITS (SLOT_BITS),
    .REG_BITS  (REG_BITS)
  ) u_decode (
    .addr     (r_addr),
    .hit_can  (dec_can),
    .hit_din  (dec_din),
    .reserved (dec_reserved),
    .can_idx  (dec_idx)
  );

  lbx_sram_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SRAM_W  (SRAM_W),
    .DEV_CNT (DEV_CNT)
  ) u_sram (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (ram_cycle),
    .write     (r_write),
    .addr_hi   (r_addr[ADDR_W-1:HI_LSB]),
    .be        (r_be),
    .wdata     (r_wdata),
    .half      (cur_half),
    .ce_n      (sram_ce_n),
    .word_addr (sram_addr),
    .lane_n    (sram_lane_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .wr_half   (sram_wdata),
    .keep_mask (keep_mask)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_start
    assign start_mask[h] = |req_be[h*LANES +: LANES];
  end

  always_comb begin
    acc_start = (state == SQ_IDLE) && req_valid;
    per_cycle = (state == SQ_PER);
    ram_cycle = (state == SQ_RAM);
    acc_done  = (state == SQ_DONE);
    cur_half  = HALF_W'(first_set(8'(pend)));
    pend_next = pend & ~(HALVES'(1) << cur_half);
    bsel      = int'(r_addr[BSEL_W-1:0]);
    if (dec_can)      per_rd = {BYTES{can_rdata}};
    else if (dec_din) per_rd = {BYTES{din_value}};
    else              per_rd = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_be    <= '0;
      r_wdata <= '0;
      pend    <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            r_write <= req_write;
            r_addr  <= req_addr;
            r_be    <= req_be;
            r_wdata <= req_wdata;
            rdata_q <= '0;
            if (req_ram) begin
              pend  <= start_mask;
              state <= (|start_mask) ? SQ_RAM : SQ_DONE;
            end else begin
              pend  <= '0;
              state <= SQ_PER;
            end
          end
        end
        SQ_PER: begin
          rdata_q <= per_rd;
          state   <= SQ_DONE;
        end
        SQ_RAM: begin
          if (!r_write) begin
            rdata_q[int'(cur_half)*SRAM_W +: SRAM_W] <= sram_rdata & keep_mask;
          end
          pend <= pend_next;
          if (pend_next == '0) state <= SQ_DONE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // Peripheral strobes
  for (genvar c = 0; c < N_CAN; c++) begin : g_can
    assign can_cs_n[c] = !(per_cycle && dec_can && (dec_idx == IDX_W'(c)));
  end

  always_comb begin
    can_rd_n  = !(per_cycle && dec_can && !r_write);
    can_wr_n  = !(per_cycle && dec_can && r_write);
    can_addr  = r_addr[REG_BITS-1:0];
    can_wdata = r_wdata[bsel*8 +: 8];
    din_rd    = per_cycle && dec_din && !r_write;
    ack       = acc_done;
    rd_data   = rdata_q;
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R9
  AST_ONE_CAN_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~can_cs_n)); // R2
  AST_NO_TARGET_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) (!(&can_cs_n) || din_rd) |-> (&sram_ce_n)); // R2
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (per_cycle && dec_reserved) |-> (&can_cs_n && !din_rd && can_rd_n && can_wr_n)); // R3
  AST_LOWER_HALF_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (ram_cycle && $past(ram_cycle)) |-> (sram_addr[0] && !$past(sram_addr[0]))); // R8
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ram_cycle && !per_cycle); // R10

endmodule

// File: tb/lbus_csel_bridge_tb.sv
module lbus_csel_bridge_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ram, req_write;
  logic [19:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        ack;
  logic [31:0] rd_data;
  logic [3:0]  can_cs_n;
  logic        can_rd_n, can_wr_n;
  logic [7:0]  can_addr, can_wdata, can_rdata;
  logic        din_rd;
  logic [7:0]  din_value;
  logic [1:0]  sram_ce_n;
  logic [17:0] sram_addr;
  logic [1:0]  sram_lane_n;
  logic        sram_we_n, sram_oe_n;
  logic [15:0] sram_wdata, sram_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbus_csel_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ram(req_ram),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
    .ack(ack), .rd_data(rd_data), .can_cs_n(can_cs_n), .can_rd_n(can_rd_n),
    .can_wr_n(can_wr_n), .can_addr(can_addr), .can_wdata(can_wdata), .can_rdata(can_rdata),
    .din_rd(din_rd), .din_value(din_value), .sram_ce_n(sram_ce_n), .sram_addr(sram_addr),
    .sram_lane_n(sram_lane_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit          is_rd;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // Bench-side RAM image and activity logs
  logic [15:0] mem [int];
  int          ram_n, can_n, din_n, rd_strobe_n;
  logic [1:0]  lg_ce   [8];
  logic [17:0] lg_addr [8];
  logic [1:0]  lg_lane [8];
  logic        lg_we   [8];
  int          lg_can_idx;
  logic [7:0]  lg_can_addr, lg_can_wd;
  logic        lg_can_wr;
  int          key, dev;
  logic [15:0] word;
  exp_t        item;

  function automatic logic [7:0] can_resp(input int idx, input logic [7:0] a);
    return (8'h30 + 8'(idx * 17)) ^ a;
  endfunction

  // Monitor: device models, logs and scoreboard, all away from the rising edge
  always @(negedge clk) begin
    if (sram_ce_n != 2'b11) begin
      dev = (sram_ce_n[1] == 1'b0) ? 1 : 0;
      key = dev * (1 << 18) + int'(sram_addr);
      if (ram_n < 8) begin
        lg_ce[ram_n]   = sram_ce_n;
        lg_addr[ram_n] = sram_addr;
        lg_lane[ram_n] = sram_lane_n;
        lg_we[ram_n]   = !sram_we_n;
      end
      ram_n++;
      word = mem.exists(key) ? mem[key] : 16'h0;
      if (!sram_we_n) begin
        if (!sram_lane_n[0]) word[7:0]  = sram_wdata[7:0];
        if (!sram_lane_n[1]) word[15:8] = sram_wdata[15:8];
        mem[key] = word;
      end else begin
        sram_rdata = word;
      end
    end
    if (can_cs_n != 4'hF) begin
      can_n++;
      for (int i = 0; i < 4; i++) if (!can_cs_n[i]) lg_can_idx = i;
      lg_can_addr = can_addr;
      lg_can_wr   = !can_wr_n;
      lg_can_wd   = can_wdata;
      if (!can_rd_n) rd_strobe_n++;
      can_rdata = can_resp(lg_can_idx, can_addr);
    end
    if (din_rd) din_n++;
    if (ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 ack without pending request", 32'(ack), 32'h0);
      end else begin
        item = exp_q.pop_front();
        if (item.is_rd) chk(rd_data == item.val, item.tag, rd_data, item.val);
      end
    end
  end

  // Driver: present a request and wait for its acknowledge
  task automatic access(input bit ram, input logic [19:0] a, input logic [3:0] be,
                        input bit wr, input logic [31:0] wd, input logic [31:0] exp_rd,
                        input string tag, input int exp_lat);
    int lat;
    exp_t e;
    ram_n = 0; can_n = 0; din_n = 0; rd_strobe_n = 0;
    e.is_rd = !wr; e.val = exp_rd; e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_ram = ram; req_addr = a; req_be = be;
    req_write = wr; req_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk); #1;
      lat++;
    end while (!ack && lat < 50);
    chk(lat == exp_lat, {tag, " latency (R9)"}, 32'(lat), 32'(exp_lat));
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", 32'(cyc_dummy()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int cyc_dummy();
    return 20000;
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ram = 1'b0; req_write = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    can_rdata = 8'h00; din_value = 8'h5C; sram_rdata = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(ack == 1'b0 && rd_data == 32'h0, "R1 ack/rd_data in reset", {31'h0, ack} ^ rd_data, 32'h0);
    chk(can_cs_n == 4'hF && sram_ce_n == 2'b11 && !din_rd, "R1 selects idle in reset",
        {26'h0, can_cs_n, sram_ce_n}, {26'h0, 4'hF, 2'b11});
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ack == 1'b0 && can_cs_n == 4'hF && sram_ce_n == 2'b11, "R1 idle after release",
        {26'h0, can_cs_n, sram_ce_n}, {26'h0, 4'hF, 2'b11});

    // R2/R5: read each controller
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 20'(i * 1024 + 'h1C), 4'hF, 1'b0, 32'h0,
             {4{can_resp(i, 8'h1C)}}, "R2 R5 controller read data", 2);
      chk(can_n == 1 && lg_can_idx == i, "R2 controller select index", 32'(lg_can_idx), 32'(i));
      chk(lg_can_addr == 8'h1C && rd_strobe_n == 1 && ram_n == 0, "R2 register offset",
          32'(lg_can_addr), 32'h1C);
      idle();
    end

    // R2/R5: controller write, lane from address bits 1:0
    access(1'b0, 20'h805, 4'hF, 1'b1, 32'hDEADBEEF, 32'h0, "R2 controller write", 2);
    chk(can_n == 1 && lg_can_idx == 2 && lg_can_wr, "R2 write select on controller 2",
        32'(lg_can_idx), 32'd2);
    chk(lg_can_wd == 8'hBE && lg_can_addr == 8'h05, "R5 write byte lane 1", 32'(lg_can_wd), 32'hBE);
    idle();

    // R3: reserved ranges
    access(1'b0, 20'h00100, 4'hF, 1'b0, 32'h0, 32'hFFFFFFFF, "R3 reserved slot tail read", 2);
    chk(can_n == 0 && din_n == 0, "R3 no select at 100h", 32'(can_n + din_n), 32'h0);
    idle();
    access(1'b0, 20'h007FF, 4'hF, 1'b0, 32'h0, 32'hFFFFFFFF, "R3 reserved 7FFh read", 2);
    chk(can_n == 0 && din_n == 0, "R3 no select at 7FFh", 32'(can_n + din_n), 32'h0);
    idle();
    access(1'b0, 20'h01000, 4'hF, 1'b0, 32'h0, 32'hFFFFFFFF, "R3 beyond window read", 2);
    chk(can_n == 0 && din_n == 0, "R3 no select beyond window", 32'(can_n + din_n), 32'h0);
    idle();
    access(1'b0, 20'h00FFE, 4'hF, 1'b0, 32'h0, 32'hFFFFFFFF, "R3 reserved FFEh read", 2);
    idle();
    access(1'b0, 20'h002F0, 4'hF, 1'b1, 32'h12345678, 32'h0, "R3 reserved write", 2);
    chk(can_n == 0 && din_n == 0 && ram_n == 0, "R3 reserved write has no strobe",
        32'(can_n + din_n + ram_n), 32'h0);
    idle();

    // R4: digital input byte
    access(1'b0, 20'h00FFF, 4'hF, 1'b0, 32'h0, 32'h5C5C5C5C, "R4 R5 input byte read", 2);
    chk(din_n == 1 && can_n == 0, "R4 one input strobe", 32'(din_n), 32'd1);
    idle();
    access(1'b0, 20'h00FFF, 4'hF, 1'b1, 32'hFFFFFFFF, 32'h0, "R4 input write", 2);
    chk(din_n == 0 && can_n == 0, "R4 write ignored", 32'(din_n + can_n), 32'h0);
    idle();

    // R6/R7/R8: 32-bit write into device 0
    access(1'b1, 20'h00010, 4'hF, 1'b1, 32'h11223344, 32'h0, "R8 dword write", 3);
    chk(ram_n == 2, "R8 two device cycles", 32'(ram_n), 32'd2);
    chk(lg_addr[0] == 18'd8 && lg_addr[1] == 18'd9, "R8 lower half first",
        {lg_addr[0][15:0], lg_addr[1][15:0]}, {16'd8, 16'd9});
    chk(lg_ce[0] == 2'b10 && lg_ce[1] == 2'b10, "R6 device 0 enabled", {30'h0, lg_ce[0]}, 32'h2);
    chk(lg_lane[0] == 2'b00 && lg_lane[1] == 2'b00 && lg_we[0] && lg_we[1], "R7 both lanes written",
        {30'h0, lg_lane[0] | lg_lane[1]}, 32'h0);
    idle();
    access(1'b1, 20'h00010, 4'hF, 1'b0, 32'h0, 32'h11223344, "R8 dword read back", 3);
    idle();

    // R6/R7: byte write into device 1, upper lane of half 1
    access(1'b1, 20'h80013, 4'b1000, 1'b1, 32'hAB000000, 32'h0, "R7 byte write", 2);
    chk(ram_n == 1 && lg_ce[0] == 2'b01, "R6 device 1 enabled", {30'h0, lg_ce[0]}, 32'h1);
    chk(lg_addr[0] == 18'd9 && lg_lane[0] == 2'b01, "R7 upper lane only",
        {14'h0, lg_addr[0]} ^ {30'h0, lg_lane[0]}, 32'd9 ^ 32'd1);
    idle();
    access(1'b1, 20'h80010, 4'b0011, 1'b1, 32'h0000BEEF, 32'h0, "R7 halfword write", 2);
    chk(ram_n == 1 && lg_addr[0] == 18'd8 && lg_lane[0] == 2'b00, "R7 half 0 both lanes",
        {14'h0, lg_addr[0]}, 32'd8);
    idle();
    access(1'b1, 20'h80010, 4'hF, 1'b0, 32'h0, 32'hAB00BEEF, "R6 R7 merged read", 3);
    idle();
    access(1'b1, 20'h80010, 4'b1000, 1'b0, 32'h0, 32'hAB000000, "R7 disabled bytes read zero", 2);
    chk(ram_n == 1, "R7 empty half skipped", 32'(ram_n), 32'd1);
    idle();
    access(1'b1, 20'h00010, 4'hF, 1'b0, 32'h0, 32'h11223344, "R6 device 0 untouched", 3);
    idle();
    access(1'b1, 20'h00010, 4'h0, 1'b0, 32'h0, 32'h0, "R7 no enables", 1);
    chk(ram_n == 0, "R7 no device cycle", 32'(ram_n), 32'd0);
    idle();

    // R10: next request presented in the ack cycle
    access(1'b1, 20'h00010, 4'hF, 1'b0, 32'h0, 32'h11223344, "R10 first of pair", 3);
    access(1'b0, 20'h0041C, 4'hF, 1'b0, 32'h0, {4{can_resp(1, 8'h1C)}}, "R10 second of pair", 3);
    chk(can_n == 1 && lg_can_idx == 1 && ram_n == 0, "R10 second select only",
        32'(lg_can_idx), 32'd1);
    idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 one ack per request", 32'(exp_q.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule